// File: doc/BRIEF.md
# Converter Conversion-Mode Sequencer

This block runs whole operations of a multi-channel analog-to-digital converter. A 2-bit mode and a 2-bit threshold code are written into a configuration register. A select/convert command carries a channel number, and a separate start trigger can request conversions without a command. The block turns each accepted command or trigger into a one-cycle conversion request with a channel number. It then files each finished 14-bit result according to the mode.

In one-shot mode every command starts one conversion on the channel it names. The result goes to a holding register, where it waits to be shifted out while the next command is in progress. In repeat mode the first command locks a channel and opens a run. Commands that arrive later in the run are dummies: each one only requests another conversion on the locked channel. Results are written into an 8-entry FIFO until the programmed threshold is reached. The run then ends and the interrupt is raised. Opening a new run discards any results that were not read. The two remaining mode codes are reserved: selecting one of them raises an error flag, and commands and triggers are refused until a valid mode is written.

Top module: `conv_mode_seq`

## Requirements
- R1: After reset, irq, cfg_err, conv_req, hold_data and rd_data are all zero. The mode is one-shot (code 00) and the threshold code is 00.
- R2: In one-shot mode (cfg_mode 00), an accepted command gives conv_req=1 in the next cycle, with conv_chan equal to cmd_chan. The cycle after done_valid, hold_data holds done_data and irq is 1. The FIFO is not written.
- R3: In repeat mode (cfg_mode 01), cfg_thr codes 00, 01, 10 and 11 set the run length to 8, 6, 4 and 2 conversions. irq stays 0 until the cycle after the done_valid that completes the run, and becomes 1 in that cycle.
- R4: During a repeat run, a command issues conv_req on the locked channel, whatever its cmd_chan is. It does not change the locked channel.
- R5: A FIFO read (rd_en) presents the oldest unread result on rd_data in the next cycle. Results come out in the order they were converted.
- R6: A read of an empty FIFO gives rd_data=0 and does not move the read pointer.
- R7: A command that opens a new repeat run discards unread FIFO contents. Only the new run's results are read back.
- R8: In repeat mode, a start trigger (trig_valid) after a run has finished opens a new run on the same channel, and conv_req is issued on that channel.
- R9: Writing mode code 10 or 11 sets cfg_err. While cfg_err is set, commands and triggers produce no conv_req.
- R10: irq clears on a FIFO read, on an accepted command or trigger, or on a configuration write, unless a result sets it in the same cycle.
- R11: In repeat mode, a done_valid that arrives when no run is open is not written to the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe; also ends any open run |
| cfg_mode | input | 2 | Mode: 00 one-shot, 01 repeat, 10/11 reserved |
| cfg_thr | input | 2 | Threshold code for repeat runs |
| cmd_valid | input | 1 | Select/convert command strobe |
| cmd_chan | input | 3 | Channel carried by the command |
| trig_valid | input | 1 | Start-trigger conversion request |
| done_valid | input | 1 | Conversion finished strobe |
| done_data | input | 14 | Conversion result |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel for the conversion request |
| hold_data | output | 14 | One-shot result holding register |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | 14 | FIFO read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt |
| cfg_err | output | 1 | Reserved mode selected |

## Verification
One-shot traffic confirms that results reach the holding register and stay out of the FIFO. Repeat runs are tried with all four threshold codes, with a dummy command on a different channel between results. These runs show whether the threshold table is decoded correctly, whether the channel stays locked, and whether FIFO order is kept. A second run started over unread data shows that old data is discarded. A result that arrives after the run has closed shows that stray results are kept out. A start trigger after a finished run shows that a new run opens on the retained channel, and reserved mode codes show that requests are refused.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'b00,
    MODE_REPEAT  = 2'b01,
    MODE_RSV_A   = 2'b10,
    MODE_RSV_B   = 2'b11
  } mode_e;

  // run length per threshold code: depth, depth-2, depth-4, depth-6
  function automatic int thr_of(input logic [1:0] code, input int depth);
    return depth - 2 * int'(code);
  endfunction
endpackage

// File: rtl/cms_fifo.sv
module cms_fifo #(
  parameter int DW    = 14,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_wr  = wr_en && !flush && (cnt_q < CW'(DEPTH));
    do_rd  = rd_en && !flush && (cnt_q != '0);
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    rdat_d = rdat_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_wr) wptr_d = bump(wptr_q);
      if (do_rd) rptr_d = bump(rptr_q);
      if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
    end
    if (rd_en) rdat_d = do_rd ? mem[rptr_q] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      rdat_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      rdat_q <= rdat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wr_data;
  end

  assign rd_data = rdat_q;
  assign count   = cnt_q;
endmodule

// File: rtl/cms_ctrl.sv
module cms_ctrl
  import cms_pkg::*;
#(
  parameter int DW    = 14,
  parameter int CHW   = 3,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_mode,
  input  logic [1:0]     cfg_thr,
  input  logic           cmd_valid,
  input  logic [CHW-1:0] cmd_chan,
  input  logic           trig_valid,
  input  logic           done_valid,
  input  logic [DW-1:0]  done_data,
  input  logic           rd_en,
  output logic           conv_req,
  output logic [CHW-1:0] conv_chan,
  output logic [DW-1:0]  hold_data,
  output logic           irq,
  output logic           cfg_err,
  output logic           run,
  output logic [CHW-1:0] chan,
  output logic           fifo_flush,
  output logic           fifo_wr
);
  mode_e          mode_q, mode_d;
  logic [1:0]     thr_q, thr_d;
  logic [CHW-1:0] chan_q, chan_d, cchan_q, cchan_d;
  logic [CW-1:0]  cnt_q, cnt_d, thr_len;
  logic [DW-1:0]  hold_q, hold_d;
  logic           run_q, run_d, irq_q, irq_d, req_q, req_d;
  logic           rsvd, is_rep, acc_cmd, acc_trig, start, take, hold_we, last;

  always_comb begin
    rsvd     = mode_q[1];
    is_rep   = (mode_q == MODE_REPEAT);
    thr_len  = CW'(thr_of(thr_q, DEPTH));
    acc_cmd  = cmd_valid && !cfg_we && !rsvd;
    acc_trig = trig_valid && !cmd_valid && !cfg_we && !rsvd;
    start    = is_rep && !run_q && (acc_cmd || acc_trig);
    take     = done_valid && !cfg_we && !start && !rsvd;
    fifo_wr  = take && is_rep && run_q;
    hold_we  = take && (mode_q == MODE_ONESHOT);
    last     = fifo_wr && ((cnt_q + 1'b1) == thr_len);

    mode_d  = cfg_we ? mode_e'(cfg_mode) : mode_q;
    thr_d   = cfg_we ? cfg_thr : thr_q;
    chan_d  = chan_q;
    if (acc_cmd && (!is_rep || !run_q)) chan_d = cmd_chan;
    req_d   = acc_cmd || acc_trig;
    cchan_d = req_d ? chan_d : cchan_q;

    cnt_d = cnt_q;
    if (start) cnt_d = '0;
    else if (fifo_wr) cnt_d = cnt_q + 1'b1;

    run_d = run_q;
    if (cfg_we || last) run_d = 1'b0;
    else if (start) run_d = 1'b1;

    hold_d = hold_we ? done_data : hold_q;

    irq_d = irq_q;
    if (hold_we || last) irq_d = 1'b1;
    else if (cfg_we || acc_cmd || acc_trig || rd_en) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_ONESHOT;
      thr_q   <= '0;
      chan_q  <= '0;
      cchan_q <= '0;
      cnt_q   <= '0;
      hold_q  <= '0;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      thr_q   <= thr_d;
      chan_q  <= chan_d;
      cchan_q <= cchan_d;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
      run_q   <= run_d;
      irq_q   <= irq_d;
      req_q   <= req_d;
    end
  end

  assign conv_req   = req_q;
  assign conv_chan  = cchan_q;
  assign hold_data  = hold_q;
  assign irq        = irq_q;
  assign cfg_err    = rsvd;
  assign run        = run_q;
  assign chan       = chan_q;
  assign fifo_flush = start;
endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq #(
  parameter int DW    = 14,
  parameter int CHW   = 3,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_mode,
  input  logic [1:0]     cfg_thr,
  input  logic           cmd_valid,
  input  logic [CHW-1:0] cmd_chan,
  input  logic           trig_valid,
  input  logic           done_valid,
  input  logic [DW-1:0]  done_data,
  output logic           conv_req,
  output logic [CHW-1:0] conv_chan,
  output logic [DW-1:0]  hold_data,
  input  logic           rd_en,
  output logic [DW-1:0]  rd_data,
  output logic           irq,
  output logic           cfg_err
);
  logic           run_w, flush_w, wr_w;
  logic [CHW-1:0] chan_w;
  logic [CW-1:0]  fifo_cnt_w;

  cms_ctrl #(.DW(DW), .CHW(CHW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_thr(cfg_thr), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
    .trig_valid(trig_valid), .done_valid(done_valid), .done_data(done_data),
    .rd_en(rd_en), .conv_req(conv_req), .conv_chan(conv_chan),
    .hold_data(hold_data), .irq(irq), .cfg_err(cfg_err), .run(run_w),
    .chan(chan_w), .fifo_flush(flush_w), .fifo_wr(wr_w)
  );

  cms_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_w), .wr_en(wr_w),
    .wr_data(done_data), .rd_en(rd_en), .rd_data(rd_data), .count(fifo_cnt_w)
  );
endmodule

// File: rtl/cms_checker.sv
module cms_checker #(
  parameter int DW    = 14,
  parameter int CHW   = 3,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic           cmd_valid,
  input logic           done_valid,
  input logic           rd_en,
  input logic           conv_req,
  input logic [CHW-1:0] conv_chan,
  input logic [DW-1:0]  rd_data,
  input logic           irq,
  input logic           cfg_err,
  input logic           run_w,
  input logic [CHW-1:0] chan_w,
  input logic [CW-1:0]  fifo_cnt_w
);
  AST_CMD_GIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cfg_err && !cfg_we) |=> conv_req); // R2
  AST_RSVD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !cfg_we) |=> !conv_req); // R9
  AST_CHAN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !cfg_we) |=> (!conv_req || conv_chan == $past(chan_w))); // R4
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_cnt_w == '0) |=> (rd_data == '0)); // R6
  AST_IRQ_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !done_valid) |=> !irq); // R10
  AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_valid)); // R3
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt_w <= CW'(DEPTH)); // R3
endmodule

bind conv_mode_seq cms_checker #(.DW(DW), .CHW(CHW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cmd_valid(cmd_valid),
  .done_valid(done_valid), .rd_en(rd_en), .conv_req(conv_req),
  .conv_chan(conv_chan), .rd_data(rd_data), .irq(irq), .cfg_err(cfg_err),
  .run_w(run_w), .chan_w(chan_w), .fifo_cnt_w(fifo_cnt_w)
);

// File: tb/conv_mode_seq_tb.sv
module conv_mode_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cmd_valid = 1'b0, trig_valid = 1'b0;
  logic        done_valid = 1'b0, rd_en = 1'b0;
  logic [1:0]  cfg_mode = '0, cfg_thr = '0;
  logic [2:0]  cmd_chan = '0;
  logic [13:0] done_data = '0;
  logic        conv_req, irq, cfg_err;
  logic [2:0]  conv_chan;
  logic [13:0] hold_data, rd_data;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  conv_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_thr(cfg_thr), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
    .trig_valid(trig_valid), .done_valid(done_valid), .done_data(done_data),
    .conv_req(conv_req), .conv_chan(conv_chan), .hold_data(hold_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .cfg_err(cfg_err)
  );

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic [1:0] t);
    cfg_mode = m; cfg_thr = t; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic send_cmd(input logic [2:0] ch);
    cmd_chan = ch; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
  endtask
  task automatic send_trig();
    trig_valid = 1'b1;
    @(negedge clk); trig_valid = 1'b0;
  endtask
  task automatic send_done(input logic [13:0] d);
    done_data = d; done_valid = 1'b1;
    @(negedge clk); done_valid = 1'b0;
  endtask
  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check(irq, 0, "R1 irq"); check(cfg_err, 0, "R1 cfg_err");
    check(conv_req, 0, "R1 conv_req"); check(hold_data, 0, "R1 hold_data");
    check(rd_data, 0, "R1 rd_data");
  endtask

  task automatic t_oneshot();
    write_cfg(2'b00, 2'b00);
    send_cmd(3'd5);
    check(conv_req, 1, "R2 conv_req"); check(conv_chan, 5, "R2 conv_chan");
    send_done(14'h1234);
    check(hold_data, 14'h1234, "R2 hold_data"); check(irq, 1, "R2 irq");
    send_cmd(3'd2);
    check(irq, 0, "R10 irq cleared by command");
    send_done(14'h0abc);
    check(hold_data, 14'h0abc, "R2 hold_data second");
    do_read();
    check(rd_data, 0, "R2 fifo bypassed"); check(irq, 0, "R10 irq cleared by read");
  endtask

  task automatic t_repeat(input logic [1:0] code, input int len);
    write_cfg(2'b01, code);
    send_cmd(3'd3);
    check(conv_chan, 3, "R4 locked channel at start");
    for (int i = 0; i < len; i++) begin
      send_done(14'(16'h100 * (code + 1) + i));
      if (i < len - 1) begin
        check(irq, 0, "R3 irq before threshold");
        send_cmd(3'd6);
        check(conv_chan, 3, "R4 dummy keeps channel");
      end
    end
    check(irq, 1, "R3 irq at threshold");
    for (int i = 0; i < len; i++) begin
      do_read();
      check(rd_data, 16'h100 * (code + 1) + i, "R5 fifo order");
      if (i == 0) check(irq, 0, "R10 irq cleared by read");
    end
    do_read(); check(rd_data, 0, "R6 empty read");
    do_read(); check(rd_data, 0, "R6 empty read repeated");
  endtask

  task automatic t_overwrite_trig();
    write_cfg(2'b01, 2'b11);
    send_cmd(3'd1);
    send_done(14'h0aa1); send_done(14'h0aa2);
    check(irq, 1, "R3 irq two-entry run");
    send_cmd(3'd2);
    check(irq, 0, "R10 irq cleared by new run");
    check(conv_chan, 2, "R7 reselected channel");
    send_done(14'h0bb1); send_done(14'h0bb2);
    send_done(14'h0ee0);
    do_read(); check(rd_data, 14'h0bb1, "R7 old results replaced");
    do_read(); check(rd_data, 14'h0bb2, "R7 second new result");
    do_read(); check(rd_data, 0, "R11 late done not stored");
    send_trig();
    check(conv_req, 1, "R8 trigger request"); check(conv_chan, 2, "R8 same channel");
    send_done(14'h0cc1); send_done(14'h0cc2);
    check(irq, 1, "R8 run by trigger completes");
    do_read(); check(rd_data, 14'h0cc1, "R8 trigger run data");
  endtask

  task automatic t_reserved();
    write_cfg(2'b10, 2'b00);
    check(cfg_err, 1, "R9 cfg_err mode 10");
    send_cmd(3'd4); check(conv_req, 0, "R9 command refused");
    send_trig(); check(conv_req, 0, "R9 trigger refused");
    write_cfg(2'b11, 2'b00);
    check(cfg_err, 1, "R9 cfg_err mode 11");
    send_cmd(3'd4); check(conv_req, 0, "R9 command refused 11");
    write_cfg(2'b00, 2'b00);
    check(cfg_err, 0, "R9 cfg_err cleared");
    send_cmd(3'd4); check(conv_req, 1, "R9 command accepted again");
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_repeat(2'b00, 8);
    t_repeat(2'b01, 6);
    t_repeat(2'b10, 4);
    t_repeat(2'b11, 2);
    t_overwrite_trig();
    t_reserved();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule